// File: doc/BRIEF.md
# Keypad Matrix Register Block

This block is the host-visible register file of an 8x8 matrix keypad controller. A host reaches ten 32-bit registers through a simple strobe bus: control, direct-key, rotary-encoder, matrix-key, auto-scan, four key-press snapshot words and a debounce-interval word. A key front end, which is not part of this block, reports already-decoded key events on a valid/row/column/release port.

An event is accepted only when the matrix is enabled and one of the two scan modes is selected. The event then updates the snapshot word that covers its pair of columns. A press ORs in one bit. A release wipes the whole word. If the matrix interrupt is enabled, the block raises a sticky flag and a single interrupt line. Reading a register that holds event flags returns its value and clears those flags, so the host needs no separate acknowledge.

Top module: `keyscan_regfile`

## Requirements
- R1: Ten registers sit at byte offsets 0x00, 0x08, ... 0x48 in this order: control, direct key, rotary encoder, matrix key, auto-scan, snapshots 0 to 3 (0x28, 0x30, 0x38, 0x40), debounce. A write stores all 32 bits, and a read returns the stored value in the cycle of the read strobe.
- R2: A read or write at any other offset, including a misaligned one, returns zero, changes no register and raises busErr for the cycle of the strobe.
- R3: A key event has no effect unless control bit 12 (matrix enable) is set and at least one of control bit 30 (one-shot scan) and bit 29 (scan on activity) is set.
- R4: An accepted press ORs bit (row + 16*(col mod 2)) into snapshot word col/2. Earlier bits are kept.
- R5: An accepted release sets the snapshot word of its column pair to zero, whatever its row.
- R6: An accepted event clears control bit 30. Control bit 29 is left unchanged.
- R7: An accepted event sets control bit 22 and drives irq high from the next cycle, but only when control bit 11 (interrupt enable) is set. Otherwise neither changes.
- R8: A control read returns the value held before the read, then clears bits 22 and 5 and drives irq low.
- R9: A rotary-encoder read clears bits 31, 30, 15 and 14, and a matrix-key read clears bit 31. All other bits are held. Reading the other registers changes nothing.
- R10: If a host write and a key event target the same register in one cycle, the write wins. If an event that raises the flag coincides with a control read, the flag and irq stay set.
- R11: After reset every register reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Host read strobe |
| wrEn | input | 1 | Host write strobe |
| addr | input | 8 | Byte offset of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of rdEn |
| busErr | output | 1 | High during an access to an unmapped offset |
| evtValid | input | 1 | Key event strobe |
| evtRow | input | 3 | Row of the key |
| evtCol | input | 3 | Column of the key |
| evtRelease | input | 1 | 1 for a release, 0 for a press |
| irq | output | 1 | Matrix interrupt |

## Verification
The event capture path is driven by a table of presses and releases across every column pair. The table places keys in even and odd columns and in the lowest and highest rows. This separates the low and high halves of each snapshot word and shows that presses accumulate, not overwrite. Releases are mixed into the table so that a release on a row other than the one pressed must still empty the word. Directed cases then cover each combination of enable and scan bits. They also cover the one-shot scan bit clearing, clear-on-read for each flag register, unmapped and misaligned offsets, and same-cycle collisions between host traffic and events.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int WordBits   = 32;
  localparam int RegCount   = 10;
  localparam int RegIdxBits = $clog2(RegCount);
  localparam int RowCount   = 8;
  localparam int ColCount   = 8;
  localparam int RowBits    = $clog2(RowCount);
  localparam int ColBits    = $clog2(ColCount);
  localparam int SnapCount  = ColCount / 2;
  localparam int SnapBits   = $clog2(SnapCount);
  localparam int BitIdxBits = $clog2(WordBits);
  localparam int HalfWord   = WordBits / 2;

  localparam int IdxCtrl    = 0;
  localparam int IdxRotary  = 2;
  localparam int IdxMatrix  = 3;
  localparam int IdxSnap0   = 5;

  localparam int OneShotBit  = 30;
  localparam int ActScanBit  = 29;
  localparam int MatFlagBit  = 22;
  localparam int MatEnBit    = 12;
  localparam int MatIrqEnBit = 11;
  localparam int DirFlagBit  = 5;

  typedef struct packed {
    logic                  wrHit;
    logic                  rdHit;
    logic [RegIdxBits-1:0] regIdx;
    logic                  evtTake;
    logic                  evtClear;
    logic [SnapBits-1:0]   snapSel;
    logic [BitIdxBits-1:0] bitSel;
    logic                  irqRaise;
  } strobes_t;

  function automatic logic [WordBits-1:0] readClearMask(input int idx);
    logic [WordBits-1:0] m;
    m = '0;
    case (idx)
      IdxCtrl:   begin m[MatFlagBit] = 1'b1; m[DirFlagBit] = 1'b1; end
      IdxRotary: begin m[31] = 1'b1; m[30] = 1'b1; m[15] = 1'b1; m[14] = 1'b1; end
      IdxMatrix: m[31] = 1'b1;
      default:   m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
  import keyscan_pkg::*;
#(
  parameter int AddrWidth = 8
) (
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [AddrWidth-1:0] addr,
  input  logic                 evtValid,
  input  logic [RowBits-1:0]   evtRow,
  input  logic [ColBits-1:0]   evtCol,
  input  logic                 evtRelease,
  input  logic [WordBits-1:0]  ctrlWord,
  output strobes_t             stb,
  output logic                 busErr
);
  localparam int WordIdxBits = AddrWidth - 3;

  logic [WordIdxBits-1:0] wordIdx;
  logic aligned;
  logic mapped;
  logic scanOn;

  always_comb begin
    wordIdx = addr[AddrWidth-1:3];
    aligned = (addr[2:0] == 3'b000);
    mapped  = aligned && (int'(wordIdx) < RegCount);
    scanOn  = ctrlWord[OneShotBit] || ctrlWord[ActScanBit];

    stb.wrHit    = wrEn && mapped;
    stb.rdHit    = rdEn && mapped;
    stb.regIdx   = RegIdxBits'(wordIdx);
    stb.evtTake  = evtValid && ctrlWord[MatEnBit] && scanOn;
    stb.evtClear = evtRelease;
    stb.snapSel  = evtCol[ColBits-1:1];
    stb.bitSel   = BitIdxBits'(evtRow) + (evtCol[0] ? BitIdxBits'(HalfWord) : '0);
    stb.irqRaise = stb.evtTake && ctrlWord[MatIrqEnBit];

    busErr = (rdEn || wrEn) && !mapped;
  end
endmodule

// File: rtl/keyscan_datapath.sv
module keyscan_datapath
  import keyscan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [WordBits-1:0] wrData,
  output logic [WordBits-1:0] rdData,
  output logic [WordBits-1:0] ctrlWord,
  output logic                irq
);
  logic [RegCount-1:0][WordBits-1:0] regQ;
  logic [RegCount-1:0][WordBits-1:0] regD;

  always_comb begin
    for (int i = 0; i < RegCount; i++) begin
      regD[i] = regQ[i];
      if (stb.rdHit && stb.regIdx == RegIdxBits'(i))
        regD[i] = regD[i] & ~readClearMask(i);
      if (stb.evtTake && (int'(stb.snapSel) + IdxSnap0 == i)) begin
        if (stb.evtClear)
          regD[i] = '0;
        else
          regD[i] = regD[i] | (WordBits'(1) << stb.bitSel);
      end
      if (stb.evtTake && i == IdxCtrl) begin
        regD[i][OneShotBit] = 1'b0;
        if (stb.irqRaise)
          regD[i][MatFlagBit] = 1'b1;
      end
      if (stb.wrHit && stb.regIdx == RegIdxBits'(i))
        regD[i] = wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
      irq  <= 1'b0;
    end else begin
      regQ <= regD;
      if (stb.irqRaise)
        irq <= 1'b1;
      else if (stb.rdHit && stb.regIdx == RegIdxBits'(IdxCtrl))
        irq <= 1'b0;
    end
  end

  assign rdData   = stb.rdHit ? regQ[stb.regIdx] : '0;
  assign ctrlWord = regQ[IdxCtrl];
endmodule

// File: rtl/keyscan_regfile.sv
module keyscan_regfile
  import keyscan_pkg::*;
#(
  parameter int AddrWidth = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [AddrWidth-1:0] addr,
  input  logic [WordBits-1:0]  wrData,
  output logic [WordBits-1:0]  rdData,
  output logic                 busErr,
  input  logic                 evtValid,
  input  logic [RowBits-1:0]   evtRow,
  input  logic [ColBits-1:0]   evtCol,
  input  logic                 evtRelease,
  output logic                 irq
);
  strobes_t            stb;
  logic [WordBits-1:0] ctrlWord;

  keyscan_ctrl #(.AddrWidth(AddrWidth)) ctrlUnit (
    .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .evtValid(evtValid), .evtRow(evtRow), .evtCol(evtCol),
    .evtRelease(evtRelease), .ctrlWord(ctrlWord),
    .stb(stb), .busErr(busErr)
  );

  keyscan_datapath dataUnit (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdData(rdData), .ctrlWord(ctrlWord), .irq(irq)
  );
endmodule

// File: rtl/keyscan_regfile_chk.sv
module keyscan_regfile_chk
  import keyscan_pkg::*;
#(
  parameter int AddrWidth = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic                 wrEn,
  input logic [AddrWidth-1:0] addr,
  input logic [WordBits-1:0]  rdData,
  input logic                 busErr,
  input logic                 evtValid,
  input logic                 irq,
  input logic [WordBits-1:0]  ctrlWord
);
  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> rdData == '0);

  // R1
  mapped_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == AddrWidth'(8'h48)) |-> !busErr);

  // R3
  gated_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !ctrlWord[MatEnBit] && !wrEn && !rdEn) |=> ($stable(irq) && $stable(ctrlWord)));

  // R6
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && ctrlWord[MatEnBit] && ctrlWord[OneShotBit] && !wrEn) |=> !ctrlWord[OneShotBit]);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(evtValid && ctrlWord[MatEnBit] && ctrlWord[MatIrqEnBit]));

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == '0 && !evtValid) |=> (!irq && !ctrlWord[MatFlagBit]));
endmodule

bind keyscan_regfile keyscan_regfile_chk #(.AddrWidth(AddrWidth)) chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
  .rdData(rdData), .busErr(busErr), .evtValid(evtValid), .irq(irq),
  .ctrlWord(ctrlWord)
);

// File: tb/keyscan_regfile_test.sv
module keyscan_regfile_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        busErr;
  logic        evtValid = 1'b0;
  logic [2:0]  evtRow = '0, evtCol = '0;
  logic        evtRelease = 1'b0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyscan_regfile uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .busErr(busErr),
    .evtValid(evtValid), .evtRow(evtRow), .evtCol(evtCol),
    .evtRelease(evtRelease), .irq(irq)
  );

  // {row, col, release, expected snapshot word after the event}
  localparam int NumVec = 9;
  localparam logic [38:0] vecTable [NumVec] = '{
    {3'd0, 3'd0, 1'b0, 32'h0000_0001},
    {3'd7, 3'd1, 1'b0, 32'h0080_0001},
    {3'd3, 3'd2, 1'b0, 32'h0000_0008},
    {3'd5, 3'd5, 1'b0, 32'h0020_0000},
    {3'd6, 3'd6, 1'b0, 32'h0000_0040},
    {3'd2, 3'd7, 1'b0, 32'h0004_0040},
    {3'd4, 3'd1, 1'b1, 32'h0000_0000},
    {3'd1, 3'd4, 1'b0, 32'h0020_0002},
    {3'd0, 3'd7, 1'b1, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    #1 e = busErr;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData; e = busErr;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic keyEvt(input logic [2:0] r, input logic [2:0] c, input logic rel);
    @(negedge clk);
    evtValid = 1'b1; evtRow = r; evtCol = c; evtRelease = rel;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    check("R11 irq", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 10; i++) begin
      busRead(8'(i * 8), d, e);
      check("R11 reg", d, 32'd0);
    end

    // R1 full-width write and readback on every offset
    for (int i = 0; i < 10; i++) busWrite(8'(i * 8), 32'hA500_0000 | (i << 8) | i, e);
    for (int i = 0; i < 10; i++) begin
      busRead(8'(i * 8), d, e);
      check("R1 readback", d, 32'hA500_0000 | (i << 8) | i);
      check("R1 err", {31'd0, e}, 32'd0);
    end
    for (int i = 0; i < 10; i++) busWrite(8'(i * 8), 32'd0, e);

    // R4 R5 table walk: enable, scan on activity, interrupt enable
    busWrite(8'h00, 32'h2000_1800, e);
    for (int v = 0; v < NumVec; v++) begin
      logic [38:0] t;
      t = vecTable[v];
      keyEvt(t[38:36], t[35:33], t[32]);
      busRead(8'h28 + 8'(t[35:34]) * 8'd8, d, e);
      check(t[32] ? "R5 release" : "R4 press", d, t[31:0]);
      check("R7 irq set", {31'd0, irq}, 32'd1);
    end

    // R8 control read returns pre-read value, clears flag, drops irq
    busRead(8'h00, d, e);
    check("R8 pre-read", d, 32'h2040_1800);
    check("R8 irq low", {31'd0, irq}, 32'd0);
    busRead(8'h00, d, e);
    check("R8 flag cleared", d, 32'h2000_1800);
    busWrite(8'h00, 32'h2040_1820, e);
    busRead(8'h00, d, e);
    check("R8 written flags", d, 32'h2040_1820);
    busRead(8'h00, d, e);
    check("R8 bits 22 and 5 cleared", d, 32'h2000_1800);

    // R10 event coinciding with control read keeps flag and irq
    @(negedge clk);
    rdEn = 1'b1; addr = 8'h00; evtValid = 1'b1; evtRow = 3'd0; evtCol = 3'd1; evtRelease = 1'b0;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0; evtValid = 1'b0;
    check("R10 read value", d, 32'h2000_1800);
    check("R10 irq kept", {31'd0, irq}, 32'd1);
    busRead(8'h00, d, e);
    check("R10 flag kept", d, 32'h2040_1800);
    busRead(8'h28, d, e);
    check("R10 event applied", d, 32'h0001_0000);

    // R10 write beats event on the same snapshot word
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h28; wrData = 32'h1234_0000;
    evtValid = 1'b1; evtRow = 3'd2; evtCol = 3'd0; evtRelease = 1'b0;
    @(negedge clk);
    wrEn = 1'b0; evtValid = 1'b0;
    busRead(8'h28, d, e);
    check("R10 write wins", d, 32'h1234_0000);
    busRead(8'h00, d, e);

    // R3 no scan mode selected
    busWrite(8'h00, 32'h0000_1800, e);
    keyEvt(3'd4, 3'd2, 1'b0);
    check("R3 no scan irq", {31'd0, irq}, 32'd0);
    busRead(8'h30, d, e);
    check("R3 no scan snap", d, 32'h0000_0008);
    // R3 matrix disabled
    busWrite(8'h00, 32'h6000_0800, e);
    keyEvt(3'd4, 3'd2, 1'b0);
    check("R3 disabled irq", {31'd0, irq}, 32'd0);
    busRead(8'h30, d, e);
    check("R3 disabled snap", d, 32'h0000_0008);
    busRead(8'h00, d, e);
    check("R3 ctrl untouched", d, 32'h6000_0800);

    // R6 one-shot scan bit self-clears
    busWrite(8'h00, 32'h4000_1800, e);
    keyEvt(3'd0, 3'd6, 1'b0);
    check("R6 irq", {31'd0, irq}, 32'd1);
    busRead(8'h00, d, e);
    check("R6 oneshot cleared", d, 32'h0040_1800);
    busRead(8'h40, d, e);
    check("R6 snap", d, 32'h0000_0001);

    // R7 no interrupt enable; R6 activity bit kept
    busWrite(8'h00, 32'h2000_1000, e);
    keyEvt(3'd1, 3'd6, 1'b0);
    check("R7 no irq", {31'd0, irq}, 32'd0);
    busRead(8'h00, d, e);
    check("R7 no flag", d, 32'h2000_1000);
    busRead(8'h40, d, e);
    check("R7 snap still captured", d, 32'h0000_0003);

    // R9 clear-on-read of rotary and matrix-key words
    busWrite(8'h10, 32'hFFFF_FFFF, e);
    busRead(8'h10, d, e);
    check("R9 rotary pre", d, 32'hFFFF_FFFF);
    busRead(8'h10, d, e);
    check("R9 rotary cleared", d, 32'h3FFF_3FFF);
    busWrite(8'h18, 32'hFFFF_FFFF, e);
    busRead(8'h18, d, e);
    busRead(8'h18, d, e);
    check("R9 matrix cleared", d, 32'h7FFF_FFFF);
    busWrite(8'h08, 32'h8000_0001, e);
    busRead(8'h08, d, e);
    busRead(8'h08, d, e);
    check("R9 direct held", d, 32'h8000_0001);

    // R2 unmapped and misaligned offsets
    busRead(8'h50, d, e);
    check("R2 read zero", d, 32'd0);
    check("R2 read err", {31'd0, e}, 32'd1);
    busRead(8'h04, d, e);
    check("R2 misaligned err", {31'd0, e}, 32'd1);
    busWrite(8'h0C, 32'hDEAD_BEEF, e);
    check("R2 write err", {31'd0, e}, 32'd1);
    busRead(8'h08, d, e);
    check("R2 write ignored", d, 32'h8000_0001);
    check("R2 mapped no err", {31'd0, e}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule